// File: doc/BRIEF.md
# L2 Cache Maintenance Sequencer

This block lets software run bulk maintenance over a range of L2 cache lines without issuing one operation per line. Software first loads a span register with a line count and the tag address of the first line. It then writes a control register with an operation type and a command. The sequencer walks the range one line at a time. For each line it places a single request on a valid/acknowledge interface toward the cache array, then steps to the next 64-byte line once the array accepts the request.

The same control register reports progress. A busy bit shows that a walk is in flight, and a result field gives the outcome once it has finished. The outcome can be a clean finish, a finish with an array error, an abort, or an abort after an error. A start is accepted only when the sequencer is idle, and an abort only while it is busy. A start whose type code is reserved, or whose count is zero, completes at once without touching the array. The span register reads back the live count and address, so software can see how far an aborted walk got.

Top module: `l2op_seq_ctrl`

## Requirements
- R1: After reset the control readback is 0x8000_0000: bit 31 reads 1 to show the sequencer is present, and all other bits read 0. The span readback is 0 and `req_valid` is low.
- R2: A write with `reg_sel`=1 while idle loads the line count from bits 63:48 and the start tag from bits 47:6. The span readback has the same layout, with bits 5:0 zero, and it follows the live count and tag. A span write while busy is ignored.
- R3: A control write (`reg_sel`=0) with command bits 1:0 = 1 is a start. It is accepted when idle, with a type other than 3 and a nonzero count. Bit 5 (busy) then reads 1 on the next cycle, result bits 8:6 read 0, and type bits 4:2 hold the written type.
- R4: While busy the block holds `req_valid` high, with `req_addr` = tag × 64 and `req_type` = the latched type, until `req_ack`. Each acknowledge advances the tag by one line and lowers the count by one.
- R5: When the acknowledge for the last line is taken, busy clears and `req_valid` drops on the next cycle. The result is then 1 (done OK), or 2 (done with error) if any acknowledge of the walk came with `req_err`.
- R6: An accepted start with a zero count issues no request and finishes at once with result 1.
- R7: A start with type 3 (reserved) issues no request and finishes at once with result 2. This takes precedence over a zero count.
- R8: Command 3 while busy aborts. Busy and `req_valid` clear on the next cycle, and the result is 3 (aborted OK), or 4 (aborted with error) if an error was seen during the walk.
- R9: A start while busy and an abort while idle are ignored. The type field is written by any control write while idle and is left unchanged by control writes while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the span register |
| reg_wdata | input | 64 | Write data |
| ctrl_rdata | output | 32 | Control/status readback |
| span_rdata | output | 64 | Live count and tag readback |
| req_valid | output | 1 | Line request to the cache array |
| req_type | output | 3 | Operation type of the request |
| req_addr | output | 48 | Byte address of the requested line |
| req_ack | input | 1 | Array accepts the current request |
| req_err | input | 1 | Error on the acknowledged line, valid with `req_ack` |

## Verification
The properties assume that the array raises `req_ack` only while `req_valid` is high, and that `req_err` matters only in an acknowledge cycle. They also assume that one write presents a single command, sampled on one edge. The bench's array stub follows these rules: it acknowledges a pending request with a one-cycle pulse, then leaves a gap of at least one cycle. It flags an error only for a line address chosen by the test, and every register write lasts exactly one clock.

// File: rtl/l2op_pkg.sv
package l2op_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_GO   = 2'd1,
    CMD_RSVD = 2'd2,
    CMD_STOP = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RES_NONE       = 3'd0,
    RES_OK         = 3'd1,
    RES_FAIL       = 3'd2,
    RES_ABORT_OK   = 3'd3,
    RES_ABORT_FAIL = 3'd4
  } res_e;

  localparam logic [2:0] TYPE_RESERVED = 3'd3;

  // control register field positions
  localparam int CMD_LSB  = 0;
  localparam int TYPE_LSB = 2;
  localparam int BUSY_BIT = 5;
  localparam int RES_LSB  = 6;
  localparam int HERE_BIT = 31;
  localparam int CTRL_W   = 32;

  typedef struct packed {
    logic go;        // start a walk
    logic go_empty;  // start with zero lines
    logic go_bad;    // start with reserved type
    logic stop;      // abort a walk
    logic type_we;   // latch written type
  } cmd_dec_t;

endpackage

// File: rtl/l2op_cmd_decode.sv
module l2op_cmd_decode
  import l2op_pkg::*;
(
  input  logic       wr_ctrl,
  input  logic [1:0] cmd,
  input  logic [2:0] op_type,
  input  logic       busy,
  input  logic       cnt_zero,
  output cmd_dec_t   dec
);

  always_comb begin
    dec = '0;
    if (wr_ctrl && !busy) begin
      dec.type_we = 1'b1;
      if (cmd == CMD_GO) begin
        if (op_type == TYPE_RESERVED) begin
          dec.go_bad = 1'b1;
        end else if (cnt_zero) begin
          dec.go_empty = 1'b1;
        end else begin
          dec.go = 1'b1;
        end
      end
    end
    if (wr_ctrl && busy && (cmd == CMD_STOP)) begin
      dec.stop = 1'b1;
    end
  end

endmodule

// File: rtl/l2op_walker.sv
module l2op_walker #(
  parameter int TAG_W = 42,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             step,
  output logic [TAG_W-1:0] tag,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             cnt_zero
);

  logic [TAG_W-1:0] tag_q, tag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    tag_d  = tag_q;
    cnt_d  = cnt_q;
    upd_en = load | step;
    if (load) begin
      tag_d = load_tag;
      cnt_d = load_cnt;
    end else if (step) begin
      tag_d = tag_q + TAG_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      tag_q <= tag_d;
      cnt_q <= cnt_d;
    end
  end

  assign tag      = tag_q;
  assign cnt      = cnt_q;
  assign last     = (cnt_q == CNT_W'(1));
  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/l2op_status.sv
module l2op_status
  import l2op_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_dec_t   dec,
  input  logic [2:0] new_type,
  input  logic       beat,
  input  logic       beat_err,
  input  logic       last,
  output logic       busy,
  output res_e       result,
  output logic [2:0] op_type
);

  logic       busy_q, busy_d;
  res_e       res_q, res_d;
  logic       err_q, err_d;
  logic [2:0] type_q, type_d;
  logic       err_any;
  logic       upd_en;

  assign err_any = err_q | (beat & beat_err);

  always_comb begin
    busy_d = busy_q;
    res_d  = res_q;
    err_d  = err_q;
    type_d = type_q;
    upd_en = dec.type_we | busy_q;
    if (dec.type_we) type_d = new_type;
    if (dec.go) begin
      busy_d = 1'b1;
      res_d  = RES_NONE;
      err_d  = 1'b0;
    end
    if (dec.go_empty) res_d = RES_OK;
    if (dec.go_bad)   res_d = RES_FAIL;
    if (busy_q) begin
      err_d = err_any;
      if (dec.stop) begin
        busy_d = 1'b0;
        if (err_any) res_d = RES_ABORT_FAIL;
        else         res_d = RES_ABORT_OK;
      end else if (beat && last) begin
        busy_d = 1'b0;
        if (err_any) res_d = RES_FAIL;
        else         res_d = RES_OK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      res_q  <= RES_NONE;
      err_q  <= 1'b0;
      type_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      res_q  <= res_d;
      err_q  <= err_d;
      type_q <= type_d;
    end
  end

  assign busy    = busy_q;
  assign result  = res_q;
  assign op_type = type_q;

endmodule

// File: rtl/l2op_seq_ctrl.sv
module l2op_seq_ctrl
  import l2op_pkg::*;
#(
  parameter  int TAG_W      = 42,
  parameter  int CNT_W      = 16,
  parameter  int LINE_SHIFT = 6,
  localparam int SPAN_W     = LINE_SHIFT + TAG_W + CNT_W,
  localparam int ADDR_W     = LINE_SHIFT + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [SPAN_W-1:0] reg_wdata,
  output logic [31:0]       ctrl_rdata,
  output logic [SPAN_W-1:0] span_rdata,
  output logic              req_valid,
  output logic [2:0]        req_type,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ack,
  input  logic              req_err
);

  localparam int TAG_LSB = LINE_SHIFT;
  localparam int CNT_LSB = LINE_SHIFT + TAG_W;

  logic             busy;
  res_e             result;
  logic [2:0]       op_type;
  cmd_dec_t         dec;
  logic [TAG_W-1:0] tag;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             cnt_zero;
  logic             wr_ctrl;
  logic             wr_span;
  logic             beat;
  logic             sig_unused;

  assign wr_ctrl    = reg_wr_en & ~reg_sel;
  assign wr_span    = reg_wr_en & reg_sel & ~busy;
  assign beat       = busy & req_ack;
  assign sig_unused = &{1'b0, reg_wdata[BUSY_BIT]};

  l2op_cmd_decode i_decode (
    .wr_ctrl  (wr_ctrl),
    .cmd      (reg_wdata[CMD_LSB +: 2]),
    .op_type  (reg_wdata[TYPE_LSB +: 3]),
    .busy     (busy),
    .cnt_zero (cnt_zero),
    .dec      (dec)
  );

  l2op_walker #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) i_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_span),
    .load_tag (reg_wdata[TAG_LSB +: TAG_W]),
    .load_cnt (reg_wdata[CNT_LSB +: CNT_W]),
    .step     (beat),
    .tag      (tag),
    .cnt      (cnt),
    .last     (last),
    .cnt_zero (cnt_zero)
  );

  l2op_status i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .new_type (reg_wdata[TYPE_LSB +: 3]),
    .beat     (beat),
    .beat_err (req_err),
    .last     (last),
    .busy     (busy),
    .result   (result),
    .op_type  (op_type)
  );

  always_comb begin
    ctrl_rdata                  = '0;
    ctrl_rdata[HERE_BIT]        = 1'b1;
    ctrl_rdata[RES_LSB +: 3]    = result;
    ctrl_rdata[BUSY_BIT]        = busy;
    ctrl_rdata[TYPE_LSB +: 3]   = op_type;
  end

  assign span_rdata = {cnt, tag, {LINE_SHIFT{1'b0}}};
  assign req_valid  = busy;
  assign req_type   = op_type;
  assign req_addr   = {tag, {LINE_SHIFT{1'b0}}};

endmodule

// File: rtl/l2op_seq_chk.sv
module l2op_seq_chk #(
  parameter  int TAG_W      = 42,
  parameter  int CNT_W      = 16,
  parameter  int LINE_SHIFT = 6,
  localparam int SPAN_W     = LINE_SHIFT + TAG_W + CNT_W,
  localparam int ADDR_W     = LINE_SHIFT + TAG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_sel,
  input logic [SPAN_W-1:0] reg_wdata,
  input logic [31:0]       ctrl_rdata,
  input logic [SPAN_W-1:0] span_rdata,
  input logic              req_valid,
  input logic [2:0]        req_type,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ack
);

  localparam int CNT_LSB = LINE_SHIFT + TAG_W;

  logic             go_wr, stop_wr;
  logic [2:0]       wtype, res_now;
  logic [CNT_W-1:0] cnt_now;

  assign go_wr   = reg_wr_en && !reg_sel && (reg_wdata[1:0] == 2'd1);
  assign stop_wr = reg_wr_en && !reg_sel && (reg_wdata[1:0] == 2'd3);
  assign wtype   = reg_wdata[4:2];
  assign res_now = ctrl_rdata[8:6];
  assign cnt_now = span_rdata[CNT_LSB +: CNT_W];

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && !stop_wr) |=>
      (req_valid && $stable(req_addr) && $stable(req_type)));

  // R4
  req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && (cnt_now > CNT_W'(1)) && !stop_wr) |=>
      (req_valid && (req_addr == $past(req_addr) + (ADDR_W'(1) << LINE_SHIFT))));

  // R5
  walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && (cnt_now == CNT_W'(1)) && !stop_wr) |=>
      (!req_valid && ((res_now == 3'd1) || (res_now == 3'd2))));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stop_wr) |=>
      (!req_valid && ((res_now == 3'd3) || (res_now == 3'd4))));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && go_wr && (wtype != 3'd3) && (cnt_now != '0)) |=>
      (req_valid && (res_now == 3'd0)));

  // R6
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && go_wr && (wtype != 3'd3) && (cnt_now == '0)) |=>
      (!req_valid && (res_now == 3'd1)));

  // R7
  reserved_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && go_wr && (wtype == 3'd3)) |=>
      (!req_valid && (res_now == 3'd2)));

  // R9
  busy_type_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_wr_en && !reg_sel) |=> $stable(ctrl_rdata[4:2]));

  // R2
  span_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> $stable(span_rdata));

endmodule

bind l2op_seq_ctrl l2op_seq_chk #(
  .TAG_W      (TAG_W),
  .CNT_W      (CNT_W),
  .LINE_SHIFT (LINE_SHIFT)
) i_l2op_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .ctrl_rdata (ctrl_rdata),
  .span_rdata (span_rdata),
  .req_valid  (req_valid),
  .req_type   (req_type),
  .req_addr   (req_addr),
  .req_ack    (req_ack)
);

// File: tb/test_l2op_seq_ctrl.sv
module test_l2op_seq_ctrl;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_sel;
  logic [63:0] reg_wdata;
  logic [31:0] ctrl_rdata;
  logic [63:0] span_rdata;
  logic        req_valid;
  logic [2:0]  req_type;
  logic [47:0] req_addr;
  logic        req_ack;
  logic        req_err;

  int          n_chk;
  int          n_fail;
  int          n_acks;
  bit          done_flag;
  logic        stub_on;
  logic [47:0] err_addr;
  logic [47:0] log_addr [0:63];
  logic [2:0]  log_type [0:63];

  l2op_seq_ctrl i_l2op_seq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .ctrl_rdata (ctrl_rdata),
    .span_rdata (span_rdata),
    .req_valid  (req_valid),
    .req_type   (req_type),
    .req_addr   (req_addr),
    .req_ack    (req_ack),
    .req_err    (req_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // array stub: one-cycle acknowledge, then a gap
  initial begin
    n_acks = 0;
    forever begin
      @(negedge clk);
      if (stub_on === 1'b1 && req_valid === 1'b1 && req_ack !== 1'b1) begin
        req_ack = 1'b1;
        req_err = (req_addr == err_addr);
        if (n_acks < 64) begin
          log_addr[n_acks] = req_addr;
          log_type[n_acks] = req_type;
        end
        n_acks = n_acks + 1;
      end else begin
        req_ack = 1'b0;
        req_err = 1'b0;
      end
    end
  end

  task automatic report_end();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report_end();
  end

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] span_of(logic [15:0] cnt, logic [41:0] tag);
    return {cnt, tag, 6'b0};
  endfunction

  task automatic write_ctrl(logic [1:0] cmd, logic [2:0] typ);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_sel   = 1'b0;
    reg_wdata = {59'b0, typ, cmd};
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic write_span(logic [15:0] cnt, logic [41:0] tag);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_sel   = 1'b1;
    reg_wdata = span_of(cnt, tag);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      if (ctrl_rdata[5] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    stub_on = 1'b0; err_addr = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 ctrl", ctrl_rdata, 32'h8000_0000);
    check_eq("R1 span", span_rdata, 64'h0);
    check_eq("R1 req_valid", req_valid, 0);
  endtask

  task automatic t_normal();
    int n0;
    write_span(16'd4, 42'h100);
    check_eq("R2 span load", span_rdata, span_of(16'd4, 42'h100));
    n0 = n_acks;
    stub_on = 1'b1;
    write_ctrl(2'd1, 3'd5);
    check_eq("R3 busy", ctrl_rdata[5], 1);
    wait_idle();
    check_eq("R5 result ok", ctrl_rdata[8:6], 3'd1);
    check_eq("R5 req_valid low", req_valid, 0);
    check_eq("R4 line count", n_acks - n0, 4);
    for (int i = 0; i < 4; i++) begin
      check_eq("R4 line addr", log_addr[n0+i], {42'h100 + 42'(i), 6'b0});
      check_eq("R4 line type", log_type[n0+i], 3'd5);
    end
    check_eq("R2 live span", span_rdata, span_of(16'd0, 42'h104));
  endtask

  task automatic t_error();
    int n0;
    err_addr = {42'h201, 6'b0};
    write_span(16'd3, 42'h200);
    n0 = n_acks;
    write_ctrl(2'd1, 3'd0);
    wait_idle();
    check_eq("R5 result err", ctrl_rdata[8:6], 3'd2);
    check_eq("R5 all lines after err", n_acks - n0, 3);
    err_addr = '1;
  endtask

  task automatic t_empty();
    int n0;
    write_span(16'd0, 42'h10);
    n0 = n_acks;
    write_ctrl(2'd1, 3'd4);
    check_eq("R6 not busy", ctrl_rdata[5], 0);
    check_eq("R6 result", ctrl_rdata[8:6], 3'd1);
    repeat (3) @(negedge clk);
    check_eq("R6 no request", n_acks - n0, 0);
  endtask

  task automatic t_reserved();
    int n0;
    write_span(16'd2, 42'h10);
    n0 = n_acks;
    write_ctrl(2'd1, 3'd3);
    check_eq("R7 not busy", ctrl_rdata[5], 0);
    check_eq("R7 result", ctrl_rdata[8:6], 3'd2);
    check_eq("R9 idle type write", ctrl_rdata[4:2], 3'd3);
    repeat (3) @(negedge clk);
    check_eq("R7 no request", n_acks - n0, 0);
    write_span(16'd0, 42'h10);
    write_ctrl(2'd1, 3'd3);
    check_eq("R7 beats zero count", ctrl_rdata[8:6], 3'd2);
  endtask

  task automatic t_ignore();
    int n0;
    stub_on = 1'b0;
    write_span(16'd5, 42'h20);
    n0 = n_acks;
    write_ctrl(2'd1, 3'd6);
    check_eq("R3 result cleared", ctrl_rdata[8:6], 3'd0);
    check_eq("R3 type latched", ctrl_rdata[4:2], 3'd6);
    check_eq("R4 req addr", req_addr, {42'h20, 6'b0});
    write_ctrl(2'd1, 3'd0);
    check_eq("R9 type kept", ctrl_rdata[4:2], 3'd6);
    check_eq("R9 restart ignored", span_rdata, span_of(16'd5, 42'h20));
    write_span(16'd9, 42'h77);
    check_eq("R2 busy span write", span_rdata, span_of(16'd5, 42'h20));
    stub_on = 1'b1;
    wait_idle();
    check_eq("R4 lines", n_acks - n0, 5);
    check_eq("R4 first line", log_addr[n0], {42'h20, 6'b0});
    check_eq("R5 ok", ctrl_rdata[8:6], 3'd1);
    write_ctrl(2'd3, 3'd6);
    check_eq("R9 idle abort result", ctrl_rdata[8:6], 3'd1);
    check_eq("R9 idle abort busy", ctrl_rdata[5], 0);
  endtask

  task automatic t_abort_ok();
    stub_on = 1'b0;
    write_span(16'd10, 42'h300);
    write_ctrl(2'd1, 3'd7);
    repeat (3) @(negedge clk);
    check_eq("R4 held", req_valid, 1);
    write_ctrl(2'd3, 3'd0);
    check_eq("R8 busy clear", ctrl_rdata[5], 0);
    check_eq("R8 req_valid", req_valid, 0);
    check_eq("R8 result", ctrl_rdata[8:6], 3'd3);
    check_eq("R9 abort keeps type", ctrl_rdata[4:2], 3'd7);
    check_eq("R2 count left", span_rdata, span_of(16'd10, 42'h300));
  endtask

  task automatic t_abort_err();
    int n0;
    err_addr = {42'h400, 6'b0};
    write_span(16'd10, 42'h400);
    n0 = n_acks;
    stub_on = 1'b1;
    write_ctrl(2'd1, 3'd4);
    for (int i = 0; i < 100; i++) begin
      if (n_acks - n0 >= 2) break;
      @(negedge clk);
    end
    stub_on = 1'b0;
    write_ctrl(2'd3, 3'd0);
    check_eq("R8 busy clear err", ctrl_rdata[5], 0);
    check_eq("R8 result err", ctrl_rdata[8:6], 3'd4);
    err_addr = '1;
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done_flag = 1'b0;
    t_reset();
    t_normal();
    t_error();
    t_empty();
    t_reserved();
    t_ignore();
    t_abort_ok();
    t_abort_err();
    repeat (4) @(negedge clk);
    report_end();
  end

endmodule